// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer. It counts pulses of a slow oscillator tick-enable that is sampled in the system clock domain. If software does not restart the count in time, the count reaches a selected limit. The block then raises a sticky interrupt flag when interrupt mode is on. Otherwise it asks for a system reset with a one-clock pulse. A 4-bit code picks the limit, which is a power of two: `2^(BASE_LOG2 + code)` ticks. With the default parameters this runs from 2048 to 1048576 ticks. At a 128 kHz tick that is about 16 ms to 8 s.

Software controls the block through one byte-wide register. The four select bits are split across that byte: the top bit sits apart from the low three. Any register write restarts the count, and so does a kick pulse. Clearing the run bit holds the counter at zero.

Top module: `wdog_prescaled`

## Requirements
- R1: Select code 0 produces a time-out after exactly 2^BASE_LOG2 ticks, counted from the restart.
- R2: Each increment of the select code, up to code NUM_CODES-1, doubles the number of ticks to time-out.
- R3: Select codes above NUM_CODES-1 (codes 10 to 15 by default) behave as code NUM_CODES-1.
- R4: Register layout for read and write:
  - bit 7 is the time-out flag; writing 1 clears it and writing 0 keeps it.
  - bit 6 is interrupt mode.
  - bit 5 is select bit 3.
  - bit 4 is run.
  - bit 3 is reserved and always reads 0.
  - bits 2:0 are select bits 2:0.
  - All bits are 0 after reset.
- R5: A one-clock kick pulse restarts the count from zero.
- R6: Any register write restarts the count from zero.
- R7: While run is 0, no time-out occurs, whatever the ticks.
- R8: The count advances only in clocks where tick_en is high. Clocks with tick_en low have no effect on the count.
- R9: In interrupt mode, a time-out sets the flag and never pulses rst_req. irq_req is high while both the flag and interrupt mode are set. The flag stays set until a write clears it.
- R10: When interrupt mode is off, a time-out drives rst_req high for exactly one clock, in the clock after the tick that completed the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oscillator tick enable, one clock per tick |
| kick | input | 1 | Restarts the watchdog count |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | output | 1 | Time-out interrupt request |
| rst_req | output | 1 | One-clock system reset request |

## Verification
The bench builds the block with BASE_LOG2=2 and NUM_CODES=10. All ten time-out lengths are therefore between 4 and 2048 ticks. The bench can walk every select code, including both ends and the reserved codes that clamp, and count the ticks to each expiry exactly. The small lengths also make it cheap to test the restart paths part-way through a count and the gaps with tick_en low.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned FLAG_BIT   = 7;
   localparam int unsigned IMODE_BIT  = 6;
   localparam int unsigned SEL_HI_BIT = 5;
   localparam int unsigned RUN_BIT    = 4;
   localparam int unsigned SEL_W      = 4;

   typedef struct packed {
      logic             flag;
      logic             imode;
      logic             run;
      logic [SEL_W-1:0] sel;
   } wdog_ctrl_t;
endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             set_flag,
   output wdog_ctrl_t       ctrl,
   output logic [REG_W-1:0] rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr) begin
         ctrl.imode <= wdata[IMODE_BIT];
         ctrl.run   <= wdata[RUN_BIT];
         ctrl.sel   <= {wdata[SEL_HI_BIT], wdata[2:0]};
         if (set_flag)
            ctrl.flag <= 1'b1;
         else if (wdata[FLAG_BIT])
            ctrl.flag <= 1'b0;
      end else if (set_flag) begin
         ctrl.flag <= 1'b1;
      end
   end

   always_comb begin
      rdata             = '0;
      rdata[FLAG_BIT]   = ctrl.flag;
      rdata[IMODE_BIT]  = ctrl.imode;
      rdata[SEL_HI_BIT] = ctrl.sel[3];
      rdata[RUN_BIT]    = ctrl.run;
      rdata[2:0]        = ctrl.sel[2:0];
   end
endmodule

// File: rtl/wdog_sel_decode.sv
module wdog_sel_decode #(
   parameter int unsigned BASE_LOG2 = 11,
   parameter int unsigned NUM_CODES = 10,
   localparam int unsigned CNT_W    = BASE_LOG2 + NUM_CODES - 1
) (
   input  logic [3:0]       sel,
   input  logic [CNT_W-1:0] cnt,
   output logic             terminal
);
   localparam logic [3:0] MAX_CODE = 4'(NUM_CODES - 1);

   logic [3:0]           code_eff;
   logic [NUM_CODES-1:0] hit;

   generate
      if (NUM_CODES < 16) begin : g_clamp
         assign code_eff = (sel > MAX_CODE) ? MAX_CODE : sel;
      end else begin : g_direct
         assign code_eff = sel;
      end
   endgenerate

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_hit
      assign hit[k] = &cnt[BASE_LOG2+k-1:0];
   end

   always_comb begin
      terminal = 1'b0;
      for (int k = 0; k < NUM_CODES; k++)
         if (code_eff == 4'(k)) terminal = hit[k];
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             terminal,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   assign wrap = !restart && tick && terminal;

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (restart)     cnt <= '0;
      else if (wrap)        cnt <= '0;
      else if (tick)        cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
   import wdog_pkg::*;
#(
   parameter int unsigned BASE_LOG2 = 11,
   parameter int unsigned NUM_CODES = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       kick,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq_req,
   output logic       rst_req
);
   localparam int unsigned CNT_W = BASE_LOG2 + NUM_CODES - 1;

   initial begin
      assert (BASE_LOG2 >= 1) else $error("BASE_LOG2 must be at least 1");
      assert (NUM_CODES >= 1 && NUM_CODES <= 16) else $error("NUM_CODES must be 1..16");
   end

   wdog_ctrl_t       ctrl;
   logic [CNT_W-1:0] cnt;
   logic             terminal, wrap, restart, set_flag;

   assign restart  = kick || reg_wr || !ctrl.run;
   assign set_flag = wrap && ctrl.imode;

   wdog_ctrl_reg u_reg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .set_flag(set_flag), .ctrl(ctrl), .rdata(reg_rdata)
   );

   wdog_sel_decode #(.BASE_LOG2(BASE_LOG2), .NUM_CODES(NUM_CODES)) u_dec (
      .sel(ctrl.sel), .cnt(cnt), .terminal(terminal)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick_en),
      .terminal(terminal), .cnt(cnt), .wrap(wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) rst_req <= 1'b0;
      else        rst_req <= wrap && !ctrl.imode;
   end

   assign irq_req = ctrl.flag && ctrl.imode;
endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       kick,
   input logic       reg_wr,
   input logic [7:0] reg_rdata,
   input logic       irq_req,
   input logic       rst_req
);
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r9_no_rst_in_imode: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> !reg_rdata[6]);

   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[7] && !reg_wr) |=> reg_rdata[7]);

   a_r7_idle_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[4] |=> !rst_req);

   a_r7_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[7]) |-> $past(reg_rdata[4]));

   a_r5_kick_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> !rst_req);

   a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[3]);

   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (reg_rdata[7] && reg_rdata[6]));
endmodule

bind wdog_prescaled wdog_prescaled_chk u_chk (
   .clk(clk), .rst_n(rst_n), .kick(kick), .reg_wr(reg_wr),
   .reg_rdata(reg_rdata), .irq_req(irq_req), .rst_req(rst_req)
);

// File: tb/wdog_prescaled_tb_top.sv
`timescale 1ns/1ps
module wdog_prescaled_tb_top;
   localparam int BASE = 2;
   localparam int NC   = 10;

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, kick = 1'b0, reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic irq_req, rst_req;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdog_prescaled #(.BASE_LOG2(BASE), .NUM_CODES(NC)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .kick(kick),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .rst_req(rst_req)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [7:0] cfg(input bit clr, input bit im, input bit run, input int code);
      logic [3:0] c = 4'(code);
      return {clr, im, c[3], run, 1'b0, c[2:0]};
   endfunction

   task automatic wr(input logic [7:0] v);
      reg_wr = 1'b1; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic ticks(input int maxn, output int n, output bit saw_rst, output bit saw_irq);
      n = 0; saw_rst = 0; saw_irq = 0;
      while (n < maxn && !saw_rst && !saw_irq) begin
         tick_en = 1'b1;
         @(negedge clk);
         n++;
         if (rst_req) saw_rst = 1;
         if (irq_req) saw_irq = 1;
      end
      tick_en = 1'b0;
   endtask

   task automatic t_reset;
      check("R4 reset rdata", reg_rdata, 0);
      check("R9 reset irq", irq_req, 0);
      check("R10 reset rst_req", rst_req, 0);
   endtask

   task automatic t_codes;
      int n; bit r, q;
      for (int c = 0; c < 16; c++) begin
         int e = 1 << (BASE + ((c > NC - 1) ? NC - 1 : c));
         wr(cfg(0, 0, 1, c));
         ticks(5000, n, r, q);
         if (c == 0)       check("R1 code0 ticks", n, e);
         else if (c < NC)  check("R2 doubling ticks", n, e);
         else              check("R3 reserved clamp ticks", n, e);
         tick_en = 1'b0;
         @(negedge clk);
         check("R10 pulse one clock", rst_req, 0);
      end
   endtask

   task automatic t_layout;
      int n; bit r, q;
      wr(8'hFF);
      check("R4 readback reserved bit", reg_rdata, 8'h77);
      wr(8'h30);
      check("R4 split select readback", reg_rdata, 8'h30);
      ticks(5000, n, r, q);
      check("R4 code8 via bit5", n, 1 << (BASE + 8));
   endtask

   task automatic t_kick;
      int n; bit r, q;
      wr(cfg(0, 0, 1, 2));
      ticks(10, n, r, q);
      kick = 1'b1; @(negedge clk); kick = 1'b0;
      ticks(100, n, r, q);
      check("R5 kick restarts", n, 16);
   endtask

   task automatic t_write_restart;
      int n; bit r, q;
      wr(cfg(0, 0, 1, 2));
      ticks(10, n, r, q);
      wr(cfg(0, 0, 1, 2));
      ticks(100, n, r, q);
      check("R6 write restarts", n, 16);
   endtask

   task automatic t_idle;
      int n; bit r, q;
      wr(cfg(0, 0, 0, 0));
      ticks(100, n, r, q);
      check("R7 stopped no reset", r, 0);
      check("R7 stopped no irq", q, 0);
   endtask

   task automatic t_gate;
      int n; bit r, q; bit seen = 0;
      wr(cfg(0, 0, 1, 0));
      ticks(3, n, r, q);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (rst_req) seen = 1;
      end
      check("R8 no expiry without ticks", seen, 0);
      ticks(10, n, r, q);
      check("R8 remaining tick count", n, 1);
   endtask

   task automatic t_irq;
      int n; bit r, q;
      wr(cfg(0, 1, 1, 0));
      ticks(100, n, r, q);
      check("R9 irq after 4 ticks", n, 4);
      check("R9 no reset in irq mode", r, 0);
      check("R9 flag readback", reg_rdata[7], 1);
      repeat (10) @(negedge clk);
      check("R9 irq sticky", irq_req, 1);
      wr(cfg(0, 1, 1, 0));
      check("R9 write 0 keeps flag", reg_rdata[7], 1);
      wr(cfg(1, 1, 1, 0));
      check("R9 flag cleared", reg_rdata[7], 0);
      check("R9 irq cleared", irq_req, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_codes();
      t_layout();
      t_kick();
      t_write_restart();
      t_idle();
      t_gate();
      t_irq();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog timeout actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule